// File: doc/BRIEF.md
# Command-Code Watchdog Timer

A watchdog for a system chip that is steered entirely by writing 16-bit command codes to a control register over a small 32-bit register bus. Its 20-bit counter counts down by one on each cycle where a slow timebase strobe is high. At the nominal 90 kHz rate the longest timeout is about 11.65 s. If software does not reload the counter before it runs out, the block raises an interrupt flag and pulses a reset request for the system.

Reloads through the count register are accepted only after an unlock command. The count register shows the top 16 bits of the counter. A value written there becomes the top 16 bits, and the low four bits are filled with ones. A separate "fill" command reloads the maximum count at any time, whether the register is locked or not. This is the normal keep-alive action. Software can force a quick restart by loading a count of 1 and then resuming.

Top module: `cmdwd_top`

## Requirements
- R1: After reset the counter is stopped, the count register is locked, the interrupt is clear, and the counter holds 0xFFFFF. A status read returns 0x2 and a count read returns 0xFFFF.
- R2: Reads are combinational in the cycle `bus_re` is high. Address 0x00 returns status: bit 0 running, bit 1 locked, bit 2 irq pending, and all other bits 0. Address 0x04 returns counter bits [19:4] in bits [15:0], with the upper bits 0. Any other address, or `bus_re` low, returns 0.
- R3: Control code 0x3877 stops the counter and 0x4A4B starts it. The counter falls by exactly one on each clock where `tick_en` is high while it is running, and holds otherwise.
- R4: Code 0xAB00 unlocks and 0xAB01 locks. A write to 0x04 while unlocked loads the counter with {wdata[15:0], 4'hF} at the next edge. While locked, such a write is ignored.
- R5: Code 0xDEAF loads 0xFFFFF into the counter whatever the lock state.
- R6: A tick while running with the counter at 1 or 0 sets the counter to 0, stops it, sets `wdt_irq`, and raises `wdt_reset` for exactly one clock. All of these become visible one clock after that tick edge.
- R7: Code 0x7482 clears the pending interrupt flag.
- R8: Any other value written to 0x00 is ignored, including a known code with nonzero bits [31:16].
- R9: A load (a fill command or an accepted count write) in the same cycle as a tick takes the loaded value, and no decrement or expiry happens in that cycle.
- R10: Unlock, count write 0x0001, lock, then resume with a tick every clock expires on the 31st tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timebase strobe; one count per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| wdt_irq | output | 1 | Interrupt flag, held until cleared |
| wdt_reset | output | 1 | One-clock reset request on expiry |

## Verification
Command and count writes change state at the clock edge where the write is sampled. Their effect is first seen on a read issued in the next cycle. Read data is combinational, so the bench compares it one time step after it drives the read strobe, between edges. An expiry raises `wdt_irq` and `wdt_reset` one clock after the tick edge that caused it. The bench's own timed model updates on the same edge as the design, and both outputs are compared against it at every falling edge. This means an interrupt or reset that arrives a cycle late, or a reset pulse that lasts two cycles, causes a miscompare.

// File: rtl/cmdwd_pkg.sv
package cmdwd_pkg;
  localparam int CMD_N = 6;

  typedef enum int {
    CMD_HALT = 0,
    CMD_RUN  = 1,
    CMD_ACK  = 2,
    CMD_OPEN = 3,
    CMD_SHUT = 4,
    CMD_FILL = 5
  } cmd_e;

  // command codes, indexed by cmd_e
  localparam logic [15:0] CMD_CODE [CMD_N] = '{
    16'h3877, 16'h4A4B, 16'h7482, 16'hAB00, 16'hAB01, 16'hDEAF
  };

  // status word bit positions
  localparam int ST_RUN  = 0;
  localparam int ST_LOCK = 1;
  localparam int ST_IRQ  = 2;
endpackage

// File: rtl/cmdwd_decode.sv
module cmdwd_decode
  import cmdwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [CMD_N-1:0]  hit
);
  // one comparator per command code; upper data bits must be zero
  for (genvar i = 0; i < CMD_N; i++) begin : g_cmp
    assign hit[i] = wr_ctrl && (wdata == DATA_W'(CMD_CODE[i]));
  end
endmodule

// File: rtl/cmdwd_counter.sv
module cmdwd_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             running,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic step;
  assign step   = running && tick_en && !load_en;
  assign expire = step && (cnt_q <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= CNT_MAX;
    else if (load_en) cnt_q <= load_val;
    else if (expire)  cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q - ONE;
  end

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);

  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_en) |=> $stable(cnt_q));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cnt_q == $past(load_val));
endmodule

// File: rtl/cmdwd_top.sv
module cmdwd_top
  import cmdwd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20,
  parameter int WIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_reset
);
  localparam int FILL_W = CNT_W - WIN_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CNT_ADDR  = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  // window value -> full count, low bits filled with ones
  function automatic logic [CNT_W-1:0] from_window(input logic [WIN_W-1:0] w);
    return {w, {FILL_W{1'b1}}};
  endfunction

  // full count -> readable window
  function automatic logic [WIN_W-1:0] to_window(input logic [CNT_W-1:0] c);
    return c[CNT_W-1:FILL_W];
  endfunction

  logic             run_q, lock_q, irq_q, rst_q;
  logic [CMD_N-1:0] hit;
  logic             wr_ctrl, wr_cnt, load_en, expire;
  logic [CNT_W-1:0] load_val, cnt_q;
  logic [DATA_W-1:0] status;

  assign wr_ctrl = bus_we && (bus_addr == CTRL_ADDR);
  assign wr_cnt  = bus_we && (bus_addr == CNT_ADDR) && !lock_q;

  cmdwd_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_ctrl (wr_ctrl),
    .wdata   (bus_wdata),
    .hit     (hit)
  );

  assign load_en  = hit[CMD_FILL] || wr_cnt;
  assign load_val = hit[CMD_FILL] ? CNT_MAX : from_window(bus_wdata[WIN_W-1:0]);

  cmdwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .running  (run_q),
    .load_en  (load_en),
    .load_val (load_val),
    .cnt_q    (cnt_q),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      lock_q <= 1'b1;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= expire;
      if (expire)              run_q <= 1'b0;
      else if (hit[CMD_HALT])  run_q <= 1'b0;
      else if (hit[CMD_RUN])   run_q <= 1'b1;
      if (hit[CMD_OPEN])       lock_q <= 1'b0;
      else if (hit[CMD_SHUT])  lock_q <= 1'b1;
      if (expire)              irq_q <= 1'b1;
      else if (hit[CMD_ACK])   irq_q <= 1'b0;
    end
  end

  assign wdt_irq   = irq_q;
  assign wdt_reset = rst_q;

  always_comb begin
    status          = '0;
    status[ST_RUN]  = run_q;
    status[ST_LOCK] = lock_q;
    status[ST_IRQ]  = irq_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == CTRL_ADDR)     bus_rdata = status;
      else if (bus_addr == CNT_ADDR) bus_rdata = DATA_W'(to_window(cnt_q));
    end
  end

  assert_expire_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (wdt_irq && wdt_reset && !run_q && cnt_q == '0));

  assert_reset_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  assert_locked_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == CNT_ADDR && lock_q && !tick_en) |=> $stable(cnt_q));

  assert_fill_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit[CMD_FILL] |=> cnt_q == CNT_MAX);

  assert_irq_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[CMD_ACK] && !expire) |=> !wdt_irq);

  assert_unknown_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && hit == '0) |=> ($stable(lock_q) && $stable(wdt_irq)));
endmodule

// File: tb/cmdwd_top_test.sv
module cmdwd_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_irq, wdt_reset;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;

  // behavioural reference state
  int m_cnt  = 'hFFFFF;
  bit m_run  = 0;
  bit m_lock = 1;
  bit m_irq  = 0;
  bit m_rst  = 0;

  always #4 clk = ~clk; // 125 MHz

  cmdwd_top uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(wdt_irq), .wdt_reset(wdt_reset)
  );

  // reference model, advanced on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 'hFFFFF; m_run = 0; m_lock = 1; m_irq = 0; m_rst = 0;
    end else begin
      bit loaded, fired, halt, go, ack, open, shut;
      loaded = 0; halt = 0; go = 0; ack = 0; open = 0; shut = 0;
      if (bus_we && bus_addr == 4'h0) begin
        case (bus_wdata)
          32'h3877: halt = 1;
          32'h4A4B: go = 1;
          32'h7482: ack = 1;
          32'hAB00: open = 1;
          32'hAB01: shut = 1;
          32'hDEAF: begin loaded = 1; m_cnt = 'hFFFFF; end
          default: ;
        endcase
      end
      if (bus_we && bus_addr == 4'h4 && !m_lock) begin
        loaded = 1;
        m_cnt = (int'(bus_wdata[15:0]) * 16) + 15;
      end
      fired = !loaded && m_run && tick_en && m_cnt <= 1;
      if (fired) m_cnt = 0;
      else if (!loaded && m_run && tick_en) m_cnt = m_cnt - 1;
      m_rst = fired;
      if (fired) m_run = 0; else if (halt) m_run = 0; else if (go) m_run = 1;
      if (open) m_lock = 0; else if (shut) m_lock = 1;
      if (fired) m_irq = 1; else if (ack) m_irq = 0;
    end
  end

  // per-clock comparison of the timed outputs (R6)
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (wdt_irq !== m_irq || wdt_reset !== m_rst) begin
        misses++;
        $display("FAIL R6 cycle %0d: irq/reset actual %b%b expected %b%b",
                 cyc, wdt_irq, wdt_reset, m_irq, m_rst);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      misses++;
      $display("FAIL watchdog: run did not end, actual cycle %0d expected < 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_wdata = '0;
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a);
    if (a == 4'h0) return {29'b0, m_irq, m_lock, m_run};
    if (a == 4'h4) return 32'(m_cnt / 16);
    return '0;
  endfunction

  task automatic rd(input logic [3:0] a, input logic [31:0] expv, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_re = 1; bus_addr = a;
    #1;
    e = model_read(a);
    vectors++;
    if (bus_rdata !== expv || e !== expv) begin
      misses++;
      $display("FAIL %s addr %0h: actual %h expected %h (model %h)", tag, a, bus_rdata, expv, e);
    end
    @(negedge clk);
    bus_re = 0;
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = tk;
    end
    @(negedge clk);
    tick_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'h0, 32'h2, "R1");
    rd(4'h4, 32'hFFFF, "R1");
    // R2 unmapped address and strobe low
    rd(4'h8, 32'h0, "R2");
    @(negedge clk); bus_addr = 4'h4; #1; vectors++;
    if (bus_rdata !== 32'h0) begin misses++; $display("FAIL R2 re low: actual %h expected 0", bus_rdata); end
    // R4 locked count write ignored
    wr(4'h4, 32'h0010);
    rd(4'h4, 32'hFFFF, "R4");
    // R4 unlock and load
    wr(4'h0, 32'hAB00);
    rd(4'h0, 32'h0, "R4");
    wr(4'h4, 32'h0010);
    rd(4'h4, 32'h0010, "R4");
    wr(4'h0, 32'hAB01);
    rd(4'h0, 32'h2, "R4");
    // R3 stopped counter holds
    idle(5, 1);
    rd(4'h4, 32'h0010, "R3");
    // R3 running: 0x10F - 16 = 0xFF -> window 0x000F
    wr(4'h0, 32'h4A4B);
    rd(4'h0, 32'h3, "R3");
    idle(16, 1);
    rd(4'h4, 32'h000F, "R3");
    wr(4'h0, 32'h3877);
    idle(8, 1);
    rd(4'h4, 32'h000F, "R3");
    // R8 unknown codes ignored
    wr(4'h0, 32'h1234);
    wr(4'h0, 32'h0001AB00);
    wr(4'h0, 32'h00014A4B);
    rd(4'h0, 32'h2, "R8");
    rd(4'h4, 32'h000F, "R8");
    // R5 fill while locked
    wr(4'h0, 32'hDEAF);
    rd(4'h4, 32'hFFFF, "R5");
    // R10 forced restart, R6 expiry
    wr(4'h0, 32'hAB00);
    wr(4'h4, 32'h0001);
    wr(4'h0, 32'hAB01);
    wr(4'h0, 32'h4A4B);
    idle(30, 1);
    rd(4'h0, 32'h3, "R10");
    idle(1, 1);
    idle(3, 0);
    rd(4'h0, 32'h6, "R6");
    rd(4'h4, 32'h0, "R6");
    // R7 clear irq
    wr(4'h0, 32'h7482);
    rd(4'h0, 32'h2, "R7");
    // R9 load in same cycle as tick
    wr(4'h0, 32'hAB00);
    wr(4'h0, 32'h4A4B);
    @(negedge clk);
    tick_en = 1; bus_we = 1; bus_addr = 4'h4; bus_wdata = 32'h0002;
    @(negedge clk);
    tick_en = 0; bus_we = 0; bus_wdata = '0;
    rd(4'h4, 32'h0002, "R9");
    @(negedge clk);
    tick_en = 1; bus_we = 1; bus_addr = 4'h0; bus_wdata = 32'hDEAF;
    @(negedge clk);
    tick_en = 0; bus_we = 0; bus_wdata = '0;
    rd(4'h4, 32'hFFFF, "R9");
    wr(4'h0, 32'h3877);
    rd(4'h0, 32'h0, "R3");
    idle(4, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule